// File: doc/BRIEF.md
# Register-Add Instruction Decoder (16/32-bit compact encodings)

This block decodes the register-plus-register add instruction of a compact variable-length instruction set. A fetch stage presents the first halfword and, when the instruction is 32 bits long, the second halfword. Two flags come with them: one says the instruction sits inside a conditional-execution group, and the other says it is the final member of that group. The decoder works out the encoding length from the top bits of the first halfword. It recognises one 32-bit form and two 16-bit forms: a three-register form and a two-register form whose destination doubles as the first source.

For a recognised instruction the decoder produces the destination and source register numbers, the flag-update decision and a shift already resolved into a kind and an amount. The shift uses the same zero-means-32 and zero-means-rotate-through-carry rules as the downstream adder, so the two connect directly. The decoder also raises a redirect when the encoding belongs to the stack-pointer add or the compare-negative instruction, and an unpredictable flag for register combinations the architecture leaves undefined. Results are registered and appear one clock after the input.

Top module: `radd_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero on the following cycle, whatever the inputs.
- R2: Outputs reflect the inputs sampled at the previous rising edge. If `in_valid` was low at that edge, or the first halfword matches no pattern, then `dec_valid` is 0 and every other output is 0.
- R3: An instruction is 32 bits when bits 15:11 of `hw_first` are 11101, 11110 or 11111. Otherwise it is 16 bits and `hw_second` has no effect on any output.
- R4: 16-bit three-register form (`hw_first[15:9]`=0001100): `rm`=bits 8:6, `rn`=bits 5:3 and `rd`=bits 2:0, each zero-extended. The shift is LSL by 0. `set_flags` = NOT `in_grp`.
- R5: 16-bit two-register form (`hw_first[15:8]`=01000100): `rd`=`rn`={bit 7, bits 2:0} and `rm`=bits 6:3. The shift is LSL by 0 and `set_flags`=0. `redir_sp`=1 when `rd`=13 or `rm`=13.
- R6: In the two-register form, `unpred`=1 when `rn` and `rm` are both 15, or when `rd`=15 with `in_grp`=1 and `grp_last`=0.
- R7: 32-bit form (`hw_first[15:5]`=11101011000): `set_flags`=`hw_first[4]`, `rn`=`hw_first[3:0]`, `rd`=`hw_second[11:8]` and `rm`=`hw_second[3:0]`. The raw shift amount is {`hw_second[14:12]`,`hw_second[7:6]`} and the shift type is `hw_second[5:4]`.
- R8: The 32-bit shift is encoded on `shift_kind` as 0=LSL, 1=LSR, 2=ASR, 3=ROR, 4=rotate-through-carry. Type 00 gives LSL by the raw amount. Types 01 and 10 give 32 when the raw amount is 0. Type 11 with a raw amount of 0 gives kind 4 with amount 1, and otherwise gives ROR by the raw amount.
- R9: In the 32-bit form, `redir_cmpneg`=1 when `rd`=15 and the S bit is set. `redir_sp`=1 when `rn`=13.
- R10: In the 32-bit form, `unpred`=1 in any of these cases: `rd`=15 with S clear, `rn`=15, `rm`=15, or the reserved bit `hw_second[15]`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Halfwords below are meaningful this cycle |
| hw_first | input | 16 | First (or only) instruction halfword |
| hw_second | input | 16 | Second halfword of a 32-bit instruction |
| in_grp | input | 1 | Instruction is inside a conditional-execution group |
| grp_last | input | 1 | Instruction is the last of its group |
| dec_valid | output | 1 | A register-add encoding was recognised |
| rd | output | 4 | Destination register index |
| rn | output | 4 | First source register index |
| rm | output | 4 | Second source register index |
| set_flags | output | 1 | Condition flags are to be updated |
| shift_kind | output | 3 | Resolved shift kind (see R8) |
| shift_amt | output | 6 | Resolved shift amount, 0 to 32 |
| redir_sp | output | 1 | Encoding belongs to the stack-pointer add |
| redir_cmpneg | output | 1 | Encoding belongs to compare-negative |
| unpred | output | 1 | Register combination is unpredictable |

## Verification
Every output is due exactly one rising edge after its inputs are applied. The bench drives inputs on the falling edge and compares on the next falling edge, half a period after the register has updated. The reference model's result for each stimulus is held for one step and compared against all fields together, so a result that arrives a cycle early or late mismatches. The reset check is made on the falling edge after a reset edge, with a recognisable instruction held on the inputs.

// File: rtl/radd_pkg.sv
package radd_pkg;

    localparam int HW_W   = 16;
    localparam int RIDX_W = 4;
    localparam int AMT_W  = 6;

    localparam logic [RIDX_W-1:0] REG_SP = RIDX_W'(13);
    localparam logic [RIDX_W-1:0] REG_PC = RIDX_W'(15);

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;

    typedef struct packed {
        shift_kind_e        kind;
        logic [AMT_W-1:0]   amt;
    } shift_t;

    typedef struct packed {
        logic               ok;
        logic [RIDX_W-1:0]  rd;
        logic [RIDX_W-1:0]  rn;
        logic [RIDX_W-1:0]  rm;
        logic               setf;
        shift_t             sh;
        logic               to_sp;
        logic               to_cmpneg;
        logic               unpred;
    } dec_t;

    localparam dec_t DEC_NONE = '0;

    // Resolve a 2-bit type and 5-bit immediate into a shift kind and amount.
    function automatic shift_t resolve_shift(input logic [1:0] ty, input logic [4:0] imm);
        shift_t s;
        s.amt = {1'b0, imm};
        case (ty)
            2'b00: s.kind = SK_LSL;
            2'b01: begin
                s.kind = SK_LSR;
                if (imm == 5'd0) s.amt = AMT_W'(32);
            end
            2'b10: begin
                s.kind = SK_ASR;
                if (imm == 5'd0) s.amt = AMT_W'(32);
            end
            default: begin
                if (imm == 5'd0) begin
                    s.kind = SK_RRX;
                    s.amt  = AMT_W'(1);
                end else begin
                    s.kind = SK_ROR;
                end
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/radd_narrow_dec.sv
module radd_narrow_dec
    import radd_pkg::*;
(
    input  logic [HW_W-1:0] hw,
    input  logic            in_grp,
    input  logic            grp_last,
    output dec_t            dec
);
    localparam logic [6:0] PAT_THREE = 7'b0001100;
    localparam logic [7:0] PAT_TWO   = 8'b01000100;

    logic             is_three;
    logic             is_two;
    logic [RIDX_W-1:0] two_d;
    logic [RIDX_W-1:0] two_m;

    assign is_three = (hw[15:9] == PAT_THREE);
    assign is_two   = (hw[15:8] == PAT_TWO);
    assign two_d    = {hw[7], hw[2:0]};
    assign two_m    = hw[6:3];

    always_comb begin
        dec = DEC_NONE;
        if (is_three) begin
            dec.ok      = 1'b1;
            dec.rm      = {1'b0, hw[8:6]};
            dec.rn      = {1'b0, hw[5:3]};
            dec.rd      = {1'b0, hw[2:0]};
            dec.setf    = ~in_grp;
            dec.sh.kind = SK_LSL;
        end else if (is_two) begin
            dec.ok      = 1'b1;
            dec.rd      = two_d;
            dec.rn      = two_d;
            dec.rm      = two_m;
            dec.sh.kind = SK_LSL;
            dec.to_sp   = (two_d == REG_SP) || (two_m == REG_SP);
            dec.unpred  = ((two_d == REG_PC) && (two_m == REG_PC)) ||
                          ((two_d == REG_PC) && in_grp && !grp_last);
        end
    end

endmodule

// File: rtl/radd_wide_dec.sv
module radd_wide_dec
    import radd_pkg::*;
(
    input  logic [HW_W-1:0] hw_hi,
    input  logic [HW_W-1:0] hw_lo,
    output dec_t            dec
);
    localparam logic [10:0] PAT_WIDE = 11'b11101011000;

    logic              s_bit;
    logic [RIDX_W-1:0] f_rn;
    logic [RIDX_W-1:0] f_rd;
    logic [RIDX_W-1:0] f_rm;
    logic [4:0]        raw_amt;

    assign s_bit   = hw_hi[4];
    assign f_rn    = hw_hi[3:0];
    assign f_rd    = hw_lo[11:8];
    assign f_rm    = hw_lo[3:0];
    assign raw_amt = {hw_lo[14:12], hw_lo[7:6]};

    always_comb begin
        dec = DEC_NONE;
        if (hw_hi[15:5] == PAT_WIDE) begin
            dec.ok        = 1'b1;
            dec.setf      = s_bit;
            dec.rn        = f_rn;
            dec.rd        = f_rd;
            dec.rm        = f_rm;
            dec.sh        = resolve_shift(hw_lo[5:4], raw_amt);
            dec.to_cmpneg = (f_rd == REG_PC) && s_bit;
            dec.to_sp     = (f_rn == REG_SP);
            dec.unpred    = ((f_rd == REG_PC) && !s_bit) || (f_rn == REG_PC) ||
                            (f_rm == REG_PC) || hw_lo[15];
        end
    end

endmodule

// File: rtl/radd_decoder.sv
module radd_decoder
    import radd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [15:0]       hw_first,
    input  logic [15:0]       hw_second,
    input  logic              in_grp,
    input  logic              grp_last,
    output logic              dec_valid,
    output logic [3:0]        rd,
    output logic [3:0]        rn,
    output logic [3:0]        rm,
    output logic              set_flags,
    output logic [2:0]        shift_kind,
    output logic [5:0]        shift_amt,
    output logic              redir_sp,
    output logic              redir_cmpneg,
    output logic              unpred
);
    logic is_wide;
    dec_t narrow_d;
    dec_t wide_d;
    dec_t next_d;
    dec_t q;

    // 32-bit encodings start with 11101, 11110 or 11111.
    assign is_wide = (hw_first[15:13] == 3'b111) && (hw_first[12:11] != 2'b00);

    radd_narrow_dec u_narrow (
        .hw       (hw_first),
        .in_grp   (in_grp),
        .grp_last (grp_last),
        .dec      (narrow_d)
    );

    radd_wide_dec u_wide (
        .hw_hi (hw_first),
        .hw_lo (hw_second),
        .dec   (wide_d)
    );

    always_comb begin
        if (!in_valid)    next_d = DEC_NONE;
        else if (is_wide) next_d = wide_d;
        else              next_d = narrow_d;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= DEC_NONE;
        else     q <= next_d;
    end

    assign dec_valid    = q.ok;
    assign rd           = q.rd;
    assign rn           = q.rn;
    assign rm           = q.rm;
    assign set_flags    = q.setf;
    assign shift_kind   = q.sh.kind;
    assign shift_amt    = q.sh.amt;
    assign redir_sp     = q.to_sp;
    assign redir_cmpneg = q.to_cmpneg;
    assign unpred       = q.unpred;

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !dec_valid && !unpred && !redir_sp); // R2
    AST_THREE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hw_first[15:9] == 7'b0001100) |=> dec_valid && (set_flags == !$past(in_grp))); // R4
    AST_TWO_NOFLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hw_first[15:8] == 8'b01000100) |=> dec_valid && !set_flags && (rn == rd)); // R5
    AST_SHIFT_AMT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && (shift_kind == 3'd1 || shift_kind == 3'd2 || shift_kind == 3'd4)) |-> shift_amt != 6'd0); // R8
    AST_CMPNEG_SRC: assert property (@(posedge clk) disable iff (rst)
        redir_cmpneg |-> (rd == 4'd15) && set_flags && dec_valid); // R9
    AST_AMT_RANGE: assert property (@(posedge clk) disable iff (rst)
        shift_amt <= 6'd32); // R8

endmodule

// File: tb/radd_decoder_bench.sv
`timescale 1ns/1ps
module radd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] hw_first = '0;
    logic [15:0] hw_second = '0;
    logic        in_grp = 1'b0;
    logic        grp_last = 1'b0;
    logic        dec_valid, set_flags, redir_sp, redir_cmpneg, unpred;
    logic [3:0]  rd, rn, rm;
    logic [2:0]  shift_kind;
    logic [5:0]  shift_amt;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    radd_decoder u_radd_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .hw_first(hw_first),
        .hw_second(hw_second), .in_grp(in_grp), .grp_last(grp_last),
        .dec_valid(dec_valid), .rd(rd), .rn(rn), .rm(rm), .set_flags(set_flags),
        .shift_kind(shift_kind), .shift_amt(shift_amt), .redir_sp(redir_sp),
        .redir_cmpneg(redir_cmpneg), .unpred(unpred)
    );

    // {valid, rd, rn, rm, setf, kind[3], amt[6], sp, cmpneg, unpred}
    function automatic logic [25:0] model(bit v, bit [15:0] a, bit [15:0] b, bit g, bit l);
        int d = 0, n = 0, m = 0, kind = 0, amt = 0;
        bit ok = 0, sf = 0, sp = 0, cn = 0, up = 0;
        if (v) begin
            if (a[15:11] == 5'b11101 || a[15:11] == 5'b11110 || a[15:11] == 5'b11111) begin
                if (a[15:5] == 11'b11101011000) begin
                    ok = 1; sf = a[4]; n = a[3:0]; d = b[11:8]; m = b[3:0];
                    amt = b[14:12] * 4 + b[7:6];
                    kind = b[5:4];
                    if ((kind == 1 || kind == 2) && amt == 0) amt = 32;
                    if (kind == 3 && amt == 0) begin kind = 4; amt = 1; end
                    cn = (d == 15) && sf;
                    sp = (n == 13);
                    up = (d == 15 && !sf) || n == 15 || m == 15 || b[15];
                end
            end else if (a[15:9] == 7'b0001100) begin
                ok = 1; m = a[8:6]; n = a[5:3]; d = a[2:0]; sf = !g;
            end else if (a[15:8] == 8'b01000100) begin
                ok = 1; d = a[7] * 8 + a[2:0]; n = d; m = a[6:3];
                sp = (d == 13) || (m == 13);
                up = (n == 15 && m == 15) || (d == 15 && g && !l);
            end
        end
        return {ok, 4'(d), 4'(n), 4'(m), sf, 3'(kind), 6'(amt), sp, cn, up};
    endfunction

    function automatic logic [25:0] observed();
        return {dec_valid, rd, rn, rm, set_flags, shift_kind, shift_amt, redir_sp, redir_cmpneg, unpred};
    endfunction

    logic [25:0] exp_val;
    string       exp_tag;
    bit          have_exp = 0;

    task automatic compare();
        logic [25:0] got;
        got = observed();
        checks++;
        if (got !== exp_val) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", exp_tag, got, exp_val);
        end
    endtask

    // Called at a falling edge: check the prior stimulus, then apply the next.
    task automatic step(bit v, bit [15:0] a, bit [15:0] b, bit g, bit l, string tag);
        @(negedge clk);
        if (have_exp) compare();
        in_valid = v; hw_first = a; hw_second = b; in_grp = g; grp_last = l;
        exp_val = model(v, a, b, g, l);
        exp_tag = tag;
        have_exp = 1;
    endtask

    initial begin
        #(4ns * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs at zero despite a valid instruction on the inputs
        in_valid = 1; hw_first = 16'b0001100_011_010_001;
        repeat (3) @(negedge clk);
        exp_val = '0; exp_tag = "R1"; compare();
        @(negedge clk);
        rst = 0;

        // R4: three-register form, outside and inside a group
        step(1, 16'b0001100_111_101_011, 16'h0000, 0, 0, "R4");
        step(1, 16'b0001100_001_010_100, 16'h0000, 1, 0, "R4");
        // R3: second halfword ignored for a 16-bit instruction
        step(1, 16'b0001100_001_010_100, 16'hFFFF, 1, 1, "R3");
        // R5: two-register form, high destination, SP redirects
        step(1, {8'b01000100, 1'b1, 4'd9, 3'b010}, 16'h0, 0, 0, "R5");
        step(1, {8'b01000100, 1'b1, 4'd3, 3'b101}, 16'h0, 0, 0, "R5");
        step(1, {8'b01000100, 1'b0, 4'd13, 3'b001}, 16'h0, 0, 0, "R5");
        // R6: unpredictable cases and the last-in-group exemption
        step(1, {8'b01000100, 1'b1, 4'd15, 3'b111}, 16'h0, 0, 0, "R6");
        step(1, {8'b01000100, 1'b1, 4'd2, 3'b111}, 16'h0, 1, 0, "R6");
        step(1, {8'b01000100, 1'b1, 4'd2, 3'b111}, 16'h0, 1, 1, "R6");
        // R7: 32-bit fields, S clear and set
        step(1, 16'b11101011000_0_0100, {1'b0, 3'b010, 4'd6, 2'b11, 2'b00, 4'd7}, 0, 0, "R7");
        step(1, 16'b11101011000_1_0011, {1'b0, 3'b000, 4'd1, 2'b01, 2'b00, 4'd2}, 1, 0, "R7");
        // R8: shift resolution corners
        step(1, 16'b11101011000_0_0001, {1'b0, 3'b000, 4'd2, 2'b00, 2'b01, 4'd3}, 0, 0, "R8");
        step(1, 16'b11101011000_0_0001, {1'b0, 3'b000, 4'd2, 2'b00, 2'b10, 4'd3}, 0, 0, "R8");
        step(1, 16'b11101011000_0_0001, {1'b0, 3'b000, 4'd2, 2'b00, 2'b11, 4'd3}, 0, 0, "R8");
        step(1, 16'b11101011000_0_0001, {1'b0, 3'b111, 4'd2, 2'b11, 2'b11, 4'd3}, 0, 0, "R8");
        step(1, 16'b11101011000_0_0001, {1'b0, 3'b000, 4'd2, 2'b00, 2'b00, 4'd3}, 0, 0, "R8");
        // R9: redirects
        step(1, 16'b11101011000_1_0010, {1'b0, 3'b000, 4'd15, 2'b00, 2'b00, 4'd3}, 0, 0, "R9");
        step(1, 16'b11101011000_0_1101, {1'b0, 3'b001, 4'd4, 2'b00, 2'b00, 4'd3}, 0, 0, "R9");
        // R10: unpredictable 32-bit cases
        step(1, 16'b11101011000_0_0010, {1'b0, 3'b000, 4'd15, 2'b00, 2'b00, 4'd3}, 0, 0, "R10");
        step(1, 16'b11101011000_1_1111, {1'b0, 3'b000, 4'd1, 2'b00, 2'b00, 4'd3}, 0, 0, "R10");
        step(1, 16'b11101011000_1_0001, {1'b0, 3'b000, 4'd1, 2'b00, 2'b00, 4'd15}, 0, 0, "R10");
        step(1, 16'b11101011000_1_0001, {1'b1, 3'b000, 4'd1, 2'b00, 2'b00, 4'd5}, 0, 0, "R10");
        // R2: idle and unmatched encodings clear everything
        step(0, 16'b0001100_111_101_011, 16'h0, 0, 0, "R2");
        step(1, 16'h4500, 16'h0, 0, 0, "R2");
        step(1, 16'b11101011001_0_0001, 16'h0102, 0, 0, "R2");
        step(1, 16'b11101011000_0_0001, 16'h0102, 0, 0, "R2");
        // R3: pattern in second halfword does not count without a wide prefix
        step(1, 16'h0000, 16'b11101011000_0_0001, 0, 0, "R3");
        // Random mix across all forms
        for (int i = 0; i < 400; i++) begin
            bit [15:0] a, b;
            int sel;
            a = 16'($urandom); b = 16'($urandom);
            sel = $urandom_range(0, 3);
            if (sel == 0) a[15:9] = 7'b0001100;
            else if (sel == 1) a[15:8] = 8'b01000100;
            else if (sel == 2) a[15:5] = 11'b11101011000;
            step(1'($urandom_range(0, 7) != 0), a, b, 1'($urandom), 1'($urandom), "R2");
        end
        step(0, 16'h0, 16'h0, 0, 0, "R2");
        @(negedge clk);
        compare();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule